// File: doc/BRIEF.md
# Two-Mode Stack Pointer Selector

This block holds the execution mode of a small microcontroller-class core that has only two modes: a thread mode for application code and a handler mode for exception handlers. It switches to handler mode when an exception is entered and back to thread mode when the handler returns. It reports whether the core is currently privileged, keeps the two banked stack pointers (main and process), and shows the one that is visible in the present mode. It also assembles an execution status word from the ALU flags, a fixed instruction-state bit and the number of the exception being serviced.

Two software control bits shape the thread-mode behaviour. One makes thread mode privileged; the other makes thread mode run on the main stack instead of the process stack. Only privileged code may change them. Exception arbitration and vector fetch are done elsewhere; this block receives already-decided entry and return strobes.

The mode logic is a two-state machine. State `MODE_THREAD` (reset state) moves to `MODE_HANDLER` on the transition *enter* (`exc_enter` high). `MODE_HANDLER` stays in `MODE_HANDLER` on *nest* (`exc_enter` high, which replaces the exception number) and moves to `MODE_THREAD` on *return* (`exc_return` high with `exc_enter` low). In `MODE_THREAD`, `exc_return` alone causes no transition.

Top module: `mode_stack_ctrl`

## Requirements
- R1: After reset the block is in thread mode (`mode_handler` = 0), unprivileged (`priv` = 0), the visible stack pointer is the process stack pointer holding `PSP_RST`, and both control bits are 0.
- R2: A cycle with `exc_enter` high puts the block in handler mode from the next cycle and captures `exc_num`; an `exc_enter` while already in handler mode keeps handler mode and replaces the captured number.
- R3: `exc_return` in handler mode with `exc_enter` low returns to thread mode from the next cycle; when both strobes are high, entry wins; `exc_return` in thread mode changes nothing.
- R4: `priv` is 1 in handler mode at all times; in thread mode it equals control bit 0 (1 = privileged thread).
- R5: Handler mode always shows the main stack pointer; thread mode shows the process stack pointer when control bit 1 is 0 and the main stack pointer when it is 1.
- R6: A `ctrl_wr` pulse loads `ctrl_wdata[1:0]` into the control bits from the next cycle only when `priv` is 1 in the writing cycle; from unprivileged thread mode the write is ignored.
- R7: A `sp_wr` pulse writes `sp_wdata` with bits 1:0 forced to 0 into the stack pointer visible in that cycle; the other stack pointer keeps its value.
- R8: `status` carries `alu_flags` (N,Z,C,V, with N in bit 31) in bits 31:28, a 1 in bit 24, the captured exception number in bits 8:0 in handler mode and 0 there in thread mode, and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_num | input | 9 | Number of the exception being entered |
| exc_return | input | 1 | Exception return strobe |
| ctrl_wr | input | 1 | Control bit write strobe |
| ctrl_wdata | input | 2 | Bit 0: privileged thread; bit 1: thread uses main stack |
| sp_wr | input | 1 | Write strobe for the visible stack pointer |
| sp_wdata | input | 32 | Stack pointer write value |
| alu_flags | input | 4 | Current N,Z,C,V flags (N is bit 3) |
| mode_handler | output | 1 | 1 in handler mode, 0 in thread mode |
| priv | output | 1 | Current privilege |
| sp_value | output | 32 | Visible stack pointer |
| status | output | 32 | Execution status word |

## Verification
Every strobe is registered once, so mode, privilege, stack selection, stored stack pointer values and the exception field all change at the first rising edge after the cycle in which the strobe is held; `alu_flags` passes to `status` with no delay. The bench drives each strobe on a falling edge, removes it on the next falling edge, and reads the outputs at that point, half a period after the updating edge, so each check sees exactly one cycle of latency. Ignored writes are judged through `priv` and `sp_value` in the cycle after the attempt, before any further stimulus.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    localparam int STAT_W      = 32;
    localparam int FLAG_MSB    = 31;
    localparam int FLAG_LSB    = 28;
    localparam int TBIT_POS    = 24;
    localparam int CTRL_W      = 2;
    localparam int CTRL_PRIV   = 0;
    localparam int CTRL_MAINSP = 1;

endpackage

// File: rtl/msc_mode_fsm.sv
module msc_mode_fsm
    import msc_pkg::*;
#(
    parameter int EXC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_enter,
    input  logic             exc_return,
    input  logic [EXC_W-1:0] exc_num,
    output mode_e            mode,
    output logic [EXC_W-1:0] exc_active
);

    mode_e            state_q;
    mode_e            state_d;
    logic [EXC_W-1:0] num_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_THREAD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: enter, nest, return
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_THREAD: begin
                if (exc_enter) begin
                    state_d = MODE_HANDLER;
                end
            end
            MODE_HANDLER: begin
                if (exc_enter) begin
                    state_d = MODE_HANDLER;
                end else if (exc_return) begin
                    state_d = MODE_THREAD;
                end
            end
        endcase
    end

    // captured exception number
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q <= '0;
        end else if (exc_enter) begin
            num_q <= exc_num;
        end else if (state_d == MODE_THREAD) begin
            num_q <= '0;
        end
    end

    // outputs
    always_comb begin
        mode       = state_q;
        exc_active = (state_q == MODE_HANDLER) ? num_q : '0;
    end

    p_enter_handler_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (mode == MODE_HANDLER));

    p_return_thread_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter && mode == MODE_HANDLER) |=> (mode == MODE_THREAD));

    p_thread_no_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter && mode == MODE_THREAD) |=> (mode == MODE_THREAD));

    p_exc_zero_thread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_THREAD) |-> (exc_active == '0));

endmodule

// File: rtl/msc_ctrl_regs.sv
module msc_ctrl_regs
    import msc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_allowed,
    input  logic [CTRL_W-1:0] wdata,
    output logic              thread_priv,
    output logic              thread_main_sp
);

    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_allowed) begin
            ctrl_q <= wdata;
        end
    end

    always_comb begin
        thread_priv    = ctrl_q[CTRL_PRIV];
        thread_main_sp = ctrl_q[CTRL_MAINSP];
    end

    p_unpriv_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_allowed) |=> $stable(ctrl_q));

    p_priv_write_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_allowed) |=> (ctrl_q == $past(wdata)));

endmodule

// File: rtl/msc_sp_bank.sv
module msc_sp_bank #(
    parameter int          SP_W    = 32,
    parameter logic [31:0] MSP_RST = 32'h2000_1000,
    parameter logic [31:0] PSP_RST = 32'h2000_0800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_main,
    input  logic            wr_en,
    input  logic [SP_W-1:0] wdata,
    output logic [SP_W-1:0] rdata
);

    localparam int NBANK    = 2;
    localparam int IDX_MAIN = 0;
    localparam int IDX_PROC = 1;

    logic [SP_W-1:0] sp_q [NBANK];
    logic [SP_W-1:0] wval;

    always_comb begin
        wval      = wdata;
        wval[1:0] = 2'b00;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [SP_W-1:0] RST_VAL =
            (b == IDX_MAIN) ? MSP_RST[SP_W-1:0] : PSP_RST[SP_W-1:0];
        logic hit;
        assign hit = wr_en && (sel_main == (b == IDX_MAIN));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sp_q[b] <= RST_VAL;
            end else if (hit) begin
                sp_q[b] <= wval;
            end
        end
    end

    assign rdata = sel_main ? sp_q[IDX_MAIN] : sp_q[IDX_PROC];

    p_other_sp_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_main) |=> $stable(sp_q[IDX_PROC]));

    p_other_sp_kept_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_main) |=> $stable(sp_q[IDX_MAIN]));

    p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sp_q[IDX_MAIN][1:0] == 2'b00 || sp_q[IDX_PROC][1:0] == 2'b00));

endmodule

// File: rtl/mode_stack_ctrl.sv
module mode_stack_ctrl
    import msc_pkg::*;
#(
    parameter int          EXC_W   = 9,
    parameter int          SP_W    = 32,
    parameter logic [31:0] MSP_RST = 32'h2000_1000,
    parameter logic [31:0] PSP_RST = 32'h2000_0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_enter,
    input  logic [EXC_W-1:0]  exc_num,
    input  logic              exc_return,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              sp_wr,
    input  logic [SP_W-1:0]   sp_wdata,
    input  logic [3:0]        alu_flags,
    output logic              mode_handler,
    output logic              priv,
    output logic [SP_W-1:0]   sp_value,
    output logic [STAT_W-1:0] status
);

    mode_e            mode;
    logic [EXC_W-1:0] exc_active;
    logic             thread_priv;
    logic             thread_main_sp;
    logic             sel_main;

    msc_mode_fsm #(.EXC_W(EXC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .exc_num    (exc_num),
        .mode       (mode),
        .exc_active (exc_active)
    );

    msc_ctrl_regs u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (ctrl_wr),
        .wr_allowed     (priv),
        .wdata          (ctrl_wdata),
        .thread_priv    (thread_priv),
        .thread_main_sp (thread_main_sp)
    );

    msc_sp_bank #(
        .SP_W    (SP_W),
        .MSP_RST (MSP_RST),
        .PSP_RST (PSP_RST)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_main (sel_main),
        .wr_en    (sp_wr),
        .wdata    (sp_wdata),
        .rdata    (sp_value)
    );

    always_comb begin
        mode_handler = (mode == MODE_HANDLER);
        priv         = mode_handler || thread_priv;
        sel_main     = mode_handler || thread_main_sp;
    end

    always_comb begin
        status                     = '0;
        status[FLAG_MSB:FLAG_LSB]  = alu_flags;
        status[TBIT_POS]           = 1'b1;
        status[EXC_W-1:0]          = exc_active;
    end

    p_handler_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_handler |-> priv);

    p_handler_main_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && !sp_wr) |=> (sp_value == $past(u_sp.sp_q[0])));

    p_tbit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[TBIT_POS] && (status[FLAG_MSB:FLAG_LSB] == alu_flags));

endmodule

// File: tb/tb_mode_stack_ctrl.sv
`timescale 1ns/1ps
module tb_mode_stack_ctrl;

    localparam logic [31:0] MSP0 = 32'h2000_1000;
    localparam logic [31:0] PSP0 = 32'h2000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_enter = 1'b0;
    logic [8:0]  exc_num = '0;
    logic        exc_return = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [1:0]  ctrl_wdata = '0;
    logic        sp_wr = 1'b0;
    logic [31:0] sp_wdata = '0;
    logic [3:0]  alu_flags = '0;
    logic        mode_handler;
    logic        priv;
    logic [31:0] sp_value;
    logic [31:0] status;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    mode_stack_ctrl dut (
        .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_num(exc_num),
        .exc_return(exc_return), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .sp_wr(sp_wr), .sp_wdata(sp_wdata), .alu_flags(alu_flags),
        .mode_handler(mode_handler), .priv(priv), .sp_value(sp_value),
        .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one-cycle strobe helpers: set on a falling edge, clear on the next;
    // outputs are read at that second falling edge
    task automatic do_enter(input logic [8:0] n, input bit also_ret);
        @(negedge clk); exc_enter = 1; exc_num = n; exc_return = also_ret;
        @(negedge clk); exc_enter = 0; exc_return = 0;
    endtask

    task automatic do_return();
        @(negedge clk); exc_return = 1;
        @(negedge clk); exc_return = 0;
    endtask

    task automatic do_ctrl(input logic [1:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic do_sp(input logic [31:0] v);
        @(negedge clk); sp_wr = 1; sp_wdata = v;
        @(negedge clk); sp_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1 mode", {31'b0, mode_handler}, 0);
        chk("R1 priv", {31'b0, priv}, 0);
        chk("R1 sp", sp_value, PSP0);
        chk("R8 status reset", status, 32'h0100_0000);
    endtask

    task automatic t_thread_sp_and_blocked_ctrl();
        do_sp(32'h1234_5677);
        chk("R7 psp write aligned", sp_value, 32'h1234_5674);
        do_ctrl(2'b11);
        chk("R6 ignored priv", {31'b0, priv}, 0);
        chk("R6 ignored stack sel", sp_value, 32'h1234_5674);
    endtask

    task automatic t_handler_entry();
        alu_flags = 4'b1010;
        do_enter(9'd15, 0);
        chk("R2 mode", {31'b0, mode_handler}, 1);
        chk("R4 handler priv", {31'b0, priv}, 1);
        chk("R5 handler msp", sp_value, MSP0);
        chk("R8 status handler", status, 32'hA100_000F);
        do_sp(32'h2000_0F00);
        chk("R7 msp write", sp_value, 32'h2000_0F00);
        do_enter(9'h12C, 0);
        chk("R2 nest number", status, 32'hA100_012C);
        do_enter(9'd5, 1);
        chk("R3 enter wins mode", {31'b0, mode_handler}, 1);
        chk("R3 enter wins number", {23'b0, status[8:0]}, 5);
    endtask

    task automatic t_return_privileged_thread();
        do_ctrl(2'b01);
        do_return();
        chk("R3 returned", {31'b0, mode_handler}, 0);
        chk("R4 priv thread", {31'b0, priv}, 1);
        chk("R5 thread psp", sp_value, 32'h1234_5674);
        chk("R8 exc zero thread", status, 32'hA100_0000);
        do_return();
        chk("R3 return in thread", {31'b0, mode_handler}, 0);
    endtask

    task automatic t_shared_stack();
        do_ctrl(2'b11);
        chk("R5 thread main sp", sp_value, 32'h2000_0F00);
        do_sp(32'h3000_0004);
        chk("R7 main via thread", sp_value, 32'h3000_0004);
        do_ctrl(2'b00);
        chk("R4 thread unpriv", {31'b0, priv}, 0);
        chk("R7 psp kept", sp_value, 32'h1234_5674);
        do_ctrl(2'b01);
        chk("R6 reenable blocked", {31'b0, priv}, 0);
        alu_flags = 4'b0101;
        #1;
        chk("R8 flags pass", status, 32'h5100_0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_thread_sp_and_blocked_ctrl();
        t_handler_entry();
        t_return_privileged_thread();
        t_shared_stack();
        finish_run();
    end

endmodule